// File: doc/BRIEF.md
# Opcode-Fetch Interrupt Override Controller

This block sits on the opcode-fetch path of an 8-bit processor core. In every opcode-fetch cycle it decides which byte reaches the instruction register: the byte read from memory, a no-operation byte while the core is halted, or a restart opcode when an interrupt or a non-maskable interrupt is taken. It also decides whether the restart-vector field of the opcode (bits 5:3) may pass, and whether the program counter must hold still for this fetch.

The block keeps the interrupt state of the core. This state is the two interrupt-enable flip-flops (the live enable and its saved copy), the maskable interrupt mode (0, 1 or 2), the halt state, a latched non-maskable request and a one-boundary suppression flag. The decoder drives strobes that update this state for halt, enable/disable, mode select, return-from-NMI, and for opcodes after which no interrupt may be taken.

A non-maskable request is edge-triggered. It waits until the next fetch that is not suppressed, and it wins over a maskable request at that fetch. A maskable request is a level. It is sampled only at fetch cycles and only while the live enable is set.

Top module: `ofi_fetch_override`

## Requirements
- R1: After reset both enable flip-flops read 0, the mode is 0, the core is not halted and no non-maskable request is pending. In a cycle with no override, `ir_byte_o` and `int_bus_o` equal `mem_data_i`.
- R2: A fetch with no halt and no accepted interrupt passes `mem_data_i` to `ir_byte_o` and `int_bus_o`, with `pass543_o`=1 and `pc_hold_o`=0.
- R3: After the halt strobe, every fetch loads 0x00 into `ir_byte_o` with `pc_hold_o`=1, until an interrupt is accepted.
- R4: An accepted maskable interrupt loads 0xFF in mode 1 or 2, and the memory byte in mode 0. `pc_hold_o`=1 in every mode.
- R5: A rising edge on `nmi_i` is latched. The next eligible fetch takes it: `ir_byte_o`=0xFF, `int_bus_o`=0x66, `pc_hold_o`=1. It is taken ahead of a maskable request in the same fetch, and that maskable request is not taken.
- R6: `pass543_o` is 0 during a fetch that takes an NMI or a mode-2 interrupt, and 1 in every other cycle.
- R7: A maskable request is not accepted while the live enable (`iff1_o`) is 0.
- R8: Taking an NMI clears `iff1_o` and keeps `iff2_o`. Taking a maskable interrupt clears both.
- R9: The enable/disable strobe writes `opsel_i[0]` (opcode bit 3) into both flip-flops. The return-from-NMI strobe copies `iff2_o` into `iff1_o`.
- R10: The mode strobe decodes opcode bits 4:3 (`opsel_i`): 00 or 01 gives mode 0, 10 gives mode 1, 11 gives mode 2. `im_o` reports the mode as 0, 1 or 2.
- R11: After the suppress strobe, the next fetch accepts no interrupt. A pending NMI stays latched and is taken at the fetch after that.
- R12: Accepting any interrupt releases the halt state from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_i | input | 1 | Opcode-fetch cycle (instruction boundary) |
| mem_data_i | input | DW | Byte read from the data bus |
| irq_i | input | 1 | Maskable interrupt request (level) |
| nmi_i | input | 1 | Non-maskable request (edge-triggered) |
| halt_op_i | input | 1 | Decoder strobe: halt opcode executed |
| di_ei_i | input | 1 | Decoder strobe: enable/disable opcode |
| im_wr_i | input | 1 | Decoder strobe: mode-select opcode |
| retn_i | input | 1 | Decoder strobe: return from NMI |
| no_ints_i | input | 1 | Decoder strobe: suppress acceptance at next boundary |
| opsel_i | input | 2 | Opcode bits 4:3 |
| ir_byte_o | output | DW | Byte loaded into the instruction register |
| int_bus_o | output | DW | Byte placed on the internal bus (NMI vector when taking NMI) |
| pass543_o | output | 1 | Opcode bits 5:3 may pass as restart vector |
| pc_hold_o | output | 1 | Inhibit program-counter increment this fetch |
| iff1_o | output | 1 | Live interrupt enable |
| iff2_o | output | 1 | Saved interrupt enable |
| im_o | output | 2 | Interrupt mode |
| halted_o | output | 1 | Halt state |

## Verification
The bench builds the block at its default width of 8 bits, with substitute bytes 0x00 and 0xFF and an NMI vector of 0x66. At this width every substitute byte and vector can be compared with the exact values the core decodes. All three modes and every mapping of bits 4:3 are reached. So are the collisions that matter: an NMI against a maskable request, an NMI edge arriving while acceptance is suppressed, and an interrupt that ends a halt.

// File: rtl/ofi_pkg.sv
package ofi_pkg;

    typedef enum logic [1:0] {
        IM_ZERO = 2'd0,
        IM_ONE  = 2'd1,
        IM_TWO  = 2'd2
    } im_mode_e;

    typedef struct packed {
        logic     iff1;
        logic     iff2;
        im_mode_e mode;
        logic     halted;
        logic     nmi_pend;
        logic     nmi_prev;
        logic     block;
    } ctl_state_t;

    // opcode bits 4:3 -> interrupt mode
    function automatic im_mode_e im_from_bits(input logic [1:0] b);
        case (b)
            2'b10:   return IM_ONE;
            2'b11:   return IM_TWO;
            default: return IM_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/ofi_arbiter.sv
module ofi_arbiter (
    input  logic fetch_i,
    input  logic nmi_pend_i,
    input  logic irq_i,
    input  logic iff1_i,
    input  logic block_i,
    output logic take_nmi_o,
    output logic take_irq_o
);
    logic eligible;

    always_comb begin
        eligible   = fetch_i & ~block_i;
        take_nmi_o = eligible & nmi_pend_i;
        take_irq_o = eligible & irq_i & iff1_i & ~nmi_pend_i;
    end

endmodule

// File: rtl/ofi_subst.sv
module ofi_subst
    import ofi_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] NOP_CODE = '0,
    parameter logic [DW-1:0] RST_CODE = '1,
    parameter logic [DW-1:0] NMI_VEC  = DW'(8'h66)
) (
    input  logic          fetch_i,
    input  logic          halted_i,
    input  logic          take_nmi_i,
    input  logic          take_irq_i,
    input  im_mode_e      mode_i,
    input  logic [DW-1:0] mem_data_i,
    output logic [DW-1:0] ir_byte_o,
    output logic [DW-1:0] int_bus_o,
    output logic          pass543_o,
    output logic          pc_hold_o
);
    logic force_rst;
    logic force_nop;

    always_comb begin
        force_rst = take_nmi_i | (take_irq_i & (mode_i != IM_ZERO));
        force_nop = fetch_i & halted_i & ~take_nmi_i & ~take_irq_i;

        if (force_rst)      ir_byte_o = RST_CODE;
        else if (force_nop) ir_byte_o = NOP_CODE;
        else                ir_byte_o = mem_data_i;

        // NMI: opcode kept off the internal bus, vector driven instead
        int_bus_o = take_nmi_i ? NMI_VEC : ir_byte_o;
        pass543_o = ~(take_nmi_i | (take_irq_i & (mode_i == IM_TWO)));
        pc_hold_o = fetch_i & (halted_i | take_nmi_i | take_irq_i);
    end

endmodule

// File: rtl/ofi_fetch_override.sv
module ofi_fetch_override
    import ofi_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] NOP_CODE = '0,
    parameter logic [DW-1:0] RST_CODE = '1,
    parameter logic [DW-1:0] NMI_VEC  = DW'(8'h66)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_i,
    input  logic [DW-1:0] mem_data_i,
    input  logic          irq_i,
    input  logic          nmi_i,
    input  logic          halt_op_i,
    input  logic          di_ei_i,
    input  logic          im_wr_i,
    input  logic          retn_i,
    input  logic          no_ints_i,
    input  logic [1:0]    opsel_i,
    output logic [DW-1:0] ir_byte_o,
    output logic [DW-1:0] int_bus_o,
    output logic          pass543_o,
    output logic          pc_hold_o,
    output logic          iff1_o,
    output logic          iff2_o,
    output logic [1:0]    im_o,
    output logic          halted_o
);
    localparam ctl_state_t RESET_STATE = '{
        iff1: 1'b0, iff2: 1'b0, mode: IM_ZERO, halted: 1'b0,
        nmi_pend: 1'b0, nmi_prev: 1'b0, block: 1'b0
    };

    ctl_state_t st_q, st_d;
    logic       take_nmi;
    logic       take_irq;

    ofi_arbiter u_arb (
        .fetch_i   (fetch_i),
        .nmi_pend_i(st_q.nmi_pend),
        .irq_i     (irq_i),
        .iff1_i    (st_q.iff1),
        .block_i   (st_q.block),
        .take_nmi_o(take_nmi),
        .take_irq_o(take_irq)
    );

    ofi_subst #(
        .DW      (DW),
        .NOP_CODE(NOP_CODE),
        .RST_CODE(RST_CODE),
        .NMI_VEC (NMI_VEC)
    ) u_subst (
        .fetch_i   (fetch_i),
        .halted_i  (st_q.halted),
        .take_nmi_i(take_nmi),
        .take_irq_i(take_irq),
        .mode_i    (st_q.mode),
        .mem_data_i(mem_data_i),
        .ir_byte_o (ir_byte_o),
        .int_bus_o (int_bus_o),
        .pass543_o (pass543_o),
        .pc_hold_o (pc_hold_o)
    );

    always_comb begin
        st_d = st_q;

        // enable flip-flops: acceptance overrides decoder strobes
        if (take_nmi) begin
            st_d.iff1 = 1'b0;
        end else if (take_irq) begin
            st_d.iff1 = 1'b0;
            st_d.iff2 = 1'b0;
        end else if (di_ei_i) begin
            st_d.iff1 = opsel_i[0];
            st_d.iff2 = opsel_i[0];
        end else if (retn_i) begin
            st_d.iff1 = st_q.iff2;
        end

        if (im_wr_i) st_d.mode = im_from_bits(opsel_i);

        if (take_nmi | take_irq) st_d.halted = 1'b0;
        else if (halt_op_i)      st_d.halted = 1'b1;

        st_d.nmi_prev = nmi_i;
        st_d.nmi_pend = (st_q.nmi_pend & ~take_nmi) | (nmi_i & ~st_q.nmi_prev);

        if (no_ints_i)    st_d.block = 1'b1;
        else if (fetch_i) st_d.block = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign iff1_o   = st_q.iff1;
    assign iff2_o   = st_q.iff2;
    assign im_o     = st_q.mode;
    assign halted_o = st_q.halted;

endmodule

// File: rtl/ofi_fetch_override_chk.sv
module ofi_fetch_override_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_i,
    input logic          retn_i,
    input logic          di_ei_i,
    input logic          irq_i,
    input logic [DW-1:0] ir_byte_o,
    input logic          pc_hold_o,
    input logic          pass543_o,
    input logic          iff1_o,
    input logic          iff2_o,
    input logic          halted_o,
    input logic          take_nmi,
    input logic          take_irq
);
    assert_halt_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && halted_o && !take_nmi && !take_irq) |-> (ir_byte_o == '0 && pc_hold_o));

    assert_nmi_keeps_iff2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!iff1_o && iff2_o == $past(iff2_o)));

    assert_irq_clears_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (!iff1_o && !iff2_o));

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && irq_i && !iff1_o) |-> !take_irq);

    assert_nmi_masks_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> !pass543_o);

    assert_retn_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retn_i && !di_ei_i && !take_nmi && !take_irq) |=> (iff1_o == $past(iff2_o)));

    assert_release_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi || take_irq) |=> !halted_o);

    assert_single_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_irq}));

endmodule

bind ofi_fetch_override ofi_fetch_override_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_i  (fetch_i),
    .retn_i   (retn_i),
    .di_ei_i  (di_ei_i),
    .irq_i    (irq_i),
    .ir_byte_o(ir_byte_o),
    .pc_hold_o(pc_hold_o),
    .pass543_o(pass543_o),
    .iff1_o   (iff1_o),
    .iff2_o   (iff2_o),
    .halted_o (halted_o),
    .take_nmi (take_nmi),
    .take_irq (take_irq)
);

// File: tb/tb_ofi_fetch_override.sv
module tb_ofi_fetch_override;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_i = 0, irq_i = 0, nmi_i = 0, halt_op_i = 0;
    logic       di_ei_i = 0, im_wr_i = 0, retn_i = 0, no_ints_i = 0;
    logic [1:0] opsel_i = 0;
    logic [7:0] mem_data_i = 0;
    logic [7:0] ir_byte_o, int_bus_o;
    logic       pass543_o, pc_hold_o, iff1_o, iff2_o, halted_o;
    logic [1:0] im_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit m_iff1, m_iff2, m_halt, m_pend, m_prev, m_block;
    int m_im;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofi_fetch_override dut (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .mem_data_i(mem_data_i),
        .irq_i(irq_i), .nmi_i(nmi_i), .halt_op_i(halt_op_i), .di_ei_i(di_ei_i),
        .im_wr_i(im_wr_i), .retn_i(retn_i), .no_ints_i(no_ints_i), .opsel_i(opsel_i),
        .ir_byte_o(ir_byte_o), .int_bus_o(int_bus_o), .pass543_o(pass543_o),
        .pc_hold_o(pc_hold_o), .iff1_o(iff1_o), .iff2_o(iff2_o), .im_o(im_o),
        .halted_o(halted_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare outputs, advance the model
    task automatic step(input string tag, input bit f, input logic [7:0] d,
                        input bit irq, input bit nmi, input bit hlt, input bit diei,
                        input bit imw, input bit rn, input bit noi, input logic [1:0] os);
        bit tn, ti;
        int e_ir, e_bus;
        @(negedge clk);
        fetch_i = f; mem_data_i = d; irq_i = irq; nmi_i = nmi; halt_op_i = hlt;
        di_ei_i = diei; im_wr_i = imw; retn_i = rn; no_ints_i = noi; opsel_i = os;
        #1;
        tn = f && m_pend && !m_block;
        ti = f && irq && m_iff1 && !m_block && !tn;
        if (tn || (ti && m_im != 0)) e_ir = 8'hFF;
        else if (ti)                 e_ir = d;
        else if (f && m_halt)        e_ir = 8'h00;
        else                         e_ir = d;
        e_bus = tn ? 8'h66 : e_ir;
        chk(tag, "ir_byte", ir_byte_o, e_ir);
        chk(tag, "int_bus", int_bus_o, e_bus);
        chk(tag, "pass543", pass543_o, !(tn || (ti && m_im == 2)));
        chk(tag, "pc_hold", pc_hold_o, f && (m_halt || tn || ti));
        chk(tag, "iff1", iff1_o, m_iff1);
        chk(tag, "iff2", iff2_o, m_iff2);
        chk(tag, "mode", im_o, m_im);
        chk(tag, "halted", halted_o, m_halt);
        // model update for the coming edge
        if (tn) m_iff1 = 0;
        else if (ti) begin m_iff1 = 0; m_iff2 = 0; end
        else if (diei) begin m_iff1 = os[0]; m_iff2 = os[0]; end
        else if (rn) m_iff1 = m_iff2;
        if (imw) m_im = (os == 2'b10) ? 1 : (os == 2'b11) ? 2 : 0;
        if (tn || ti) m_halt = 0;
        else if (hlt) m_halt = 1;
        m_pend = (m_pend && !tn) || (nmi && !m_prev);
        m_prev = nmi;
        if (noi) m_block = 1;
        else if (f) m_block = 0;
    endtask

    task automatic idle(input string tag, input logic [7:0] d);
        step(tag, 0, d, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    endtask
    task automatic fetch(input string tag, input logic [7:0] d, input bit irq);
        step(tag, 1, d, irq, 0, 0, 0, 0, 0, 0, 2'b00);
    endtask
    task automatic set_ie(input string tag, input bit en);
        step(tag, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, {1'b0, en});
    endtask
    task automatic set_mode(input string tag, input logic [1:0] b);
        step(tag, 0, 8'h00, 0, 0, 0, 0, 1, 0, 0, b);
    endtask
    task automatic nmi_pulse(input string tag);
        step(tag, 0, 8'h00, 0, 1, 0, 0, 0, 0, 0, 2'b00);
        idle(tag, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_iff1 = 0; m_iff2 = 0; m_halt = 0; m_pend = 0; m_prev = 0; m_block = 0; m_im = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        idle("R1", 8'h3C);                         // reset state, data passes
        fetch("R2", 8'hA5, 0);                     // plain fetch
        fetch("R2", 8'h5A, 0);
        fetch("R7", 8'h77, 1);                     // irq ignored, iff1 = 0

        set_ie("R9", 1);                           // EI: bit3 = 1
        set_mode("R10", 2'b10);                    // mode 1
        fetch("R4", 8'h12, 1);                     // 0xFF, both iff cleared (R8)
        idle("R8", 8'h00);

        set_ie("R9", 1);
        set_mode("R10", 2'b11);                    // mode 2
        fetch("R6", 8'h34, 1);                     // 0xFF, field masked
        set_ie("R9", 1);
        set_mode("R10", 2'b00);                    // mode 0
        fetch("R4", 8'hC7, 1);                     // bus byte passes
        set_ie("R9", 1);
        set_mode("R10", 2'b01);                    // 01 also mode 0
        fetch("R10", 8'hD7, 1);

        set_ie("R9", 1);
        step("R3", 0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 2'b00);  // halt strobe
        fetch("R3", 8'h99, 0);
        fetch("R3", 8'h98, 0);
        idle("R3", 8'h11);
        nmi_pulse("R5");
        fetch("R12", 8'h44, 0);                    // NMI ends halt, iff2 kept
        fetch("R12", 8'h45, 0);
        step("R9", 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 2'b00);  // RETN
        idle("R9", 8'h00);

        step("R11", 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 2'b00); // suppress
        nmi_pulse("R11");
        fetch("R11", 8'h21, 1);                    // nothing taken
        fetch("R11", 8'h22, 1);                    // NMI taken now

        set_ie("R9", 1);
        set_mode("R10", 2'b10);
        nmi_pulse("R5");
        fetch("R5", 8'h55, 1);                     // NMI wins over irq
        step("R9", 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 2'b00);  // RETN restores 1
        fetch("R4", 8'h56, 1);                     // the waiting irq now taken
        set_ie("R9", 1);
        set_ie("R9", 0);                           // DI
        fetch("R7", 8'h57, 1);
        idle("R1", 8'hE1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule